// File: doc/BRIEF.md
# Parallel Camera Pixel Reconstructor

This block takes the byte-wide video stream of a parallel camera and rebuilds whole 16-bit RGB565 pixels, each tagged with its column and row inside the frame. The camera's pixel clock, two active-low sync lines and the byte bus all arrive as plain inputs. A faster system clock samples them. A rising transition of the pixel clock, seen in the sampled copy, marks the only moments when the other camera lines carry meaning.

Each pixel takes two consecutive data bytes, most significant byte first. When the second byte lands, the block raises a valid strobe for one system-clock cycle and presents the pixel word and its coordinates. A falling edge of the horizontal sync starts a new row. A low vertical sync sends the coordinates back to the top-left corner. A byte pairing that is left open when a sync region begins is dropped, so no pixel can mix bytes from two rows.

Top module: `cam_pix_rebuild`

## Requirements
- R1: The camera sync and byte lines are taken only at a system-clock cycle where the sampled pixel clock has just gone from 0 to 1. Changes on them while the pixel clock stays high or low have no effect.
- R2: A pixel is built from two consecutive valid bytes. The output word is {first byte, second byte}, so the first byte sits in bits 15:8.
- R3: A byte is valid only when both the horizontal and vertical sync inputs are 1 at its sample point. A byte sampled with either sync at 0 produces no pixel and is not paired.
- R4: Within a row, the first pixel carries horizontal count 0 and each further pixel carries the previous count plus one.
- R5: With vertical sync high, a 1-to-0 change of horizontal sync between two successive sample points sets the next pixel's horizontal count to 0 and raises the vertical count by one.
- R6: A sample with vertical sync at 0 sets the next pixel's coordinates to horizontal 0, vertical 0. Horizontal sync edges seen while vertical sync is 0 do not move the vertical count.
- R7: Any sync-region sample clears the byte pairing. An unpaired byte left at the end of a row is discarded, and the next row's first pixel is built from that row's first two bytes.
- R8: The valid output is high for exactly one system-clock cycle per completed pixel and never for two cycles in a row.
- R9: Both coordinate counters wrap to 0 after their all-ones value, at widths set by the parameters.
- R10: Synchronous reset drives the valid output, pixel word and both coordinate outputs to 0 and clears the pairing and sync history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the pixel clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk_i | input | 1 | Camera pixel clock, sampled as data |
| cam_hsync_n_i | input | 1 | Horizontal sync, active low |
| cam_vsync_n_i | input | 1 | Vertical sync, active low |
| cam_byte_i | input | 8 | Camera byte bus |
| pix_valid_o | output | 1 | One-cycle strobe for each completed pixel |
| pix_h_o | output | H_W | Horizontal count of the pixel |
| pix_v_o | output | V_W | Vertical count of the pixel |
| pix_data_o | output | 16 | Rebuilt pixel word, first byte in the upper half |

## Verification
The bench builds the block with H_W = 4 and V_W = 3. With these narrow counters, an 18-pixel row wraps the horizontal count, and a run of short rows in one frame wraps the vertical count. Full-size frames are not needed for either case. The camera model holds the pixel clock low for two system cycles and high for two. It corrupts the byte bus while the clock is high. It toggles horizontal sync during vertical blanking and leaves an odd byte at the end of one row.

// File: rtl/cam_pix_pkg.sv
package cam_pix_pkg;

    localparam int CAM_BYTE_W = 8;
    localparam int PIX_W      = 2 * CAM_BYTE_W;

    typedef logic [CAM_BYTE_W-1:0] cam_byte_t;
    typedef logic [PIX_W-1:0]      pix_word_t;

    // One registered copy of the camera lines
    typedef struct packed {
        logic      pclk;
        logic      hs_n;
        logic      vs_n;
        cam_byte_t dat;
    } cam_lines_t;

    // Meaning of a sample point
    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_SYNC = 2'd1,
        SK_DATA = 2'd2
    } smp_kind_e;

endpackage

// File: rtl/cam_edge_sampler.sv
module cam_edge_sampler
    import cam_pix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pclk_i,
    input  logic       hs_n_i,
    input  logic       vs_n_i,
    input  cam_byte_t  dat_i,
    output logic       stb_o,
    output smp_kind_e  kind_o,
    output logic       hs_n_o,
    output logic       vs_n_o,
    output cam_byte_t  dat_o
);

    typedef struct packed {
        cam_lines_t cur;
        logic       pclk_prev;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.cur.pclk  = pclk_i;
        st_d.cur.hs_n  = hs_n_i;
        st_d.cur.vs_n  = vs_n_i;
        st_d.cur.dat   = dat_i;
        st_d.pclk_prev = st_q.cur.pclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            // clock history starts high so reset release never looks like an edge
            st_q.cur.pclk  <= 1'b1;
            st_q.cur.hs_n  <= 1'b0;
            st_q.cur.vs_n  <= 1'b0;
            st_q.cur.dat   <= '0;
            st_q.pclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stb_o  = st_q.cur.pclk & ~st_q.pclk_prev;
        hs_n_o = st_q.cur.hs_n;
        vs_n_o = st_q.cur.vs_n;
        dat_o  = st_q.cur.dat;
        if (!stb_o)
            kind_o = SK_NONE;
        else if (st_q.cur.hs_n && st_q.cur.vs_n)
            kind_o = SK_DATA;
        else
            kind_o = SK_SYNC;
    end

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o); // R8

endmodule

// File: rtl/cam_byte_pairer.sv
module cam_byte_pairer
    import cam_pix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  smp_kind_e  kind_i,
    input  cam_byte_t  dat_i,
    output logic       fire_o,
    output logic       valid_o,
    output pix_word_t  word_o
);

    typedef struct packed {
        logic      half;
        cam_byte_t hi;
        logic      valid;
        pix_word_t word;
    } pair_state_t;

    pair_state_t st_d, st_q;

    assign fire_o = (kind_i == SK_DATA) && st_q.half;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (kind_i)
            SK_DATA: begin
                if (st_q.half) begin
                    st_d.half  = 1'b0;
                    st_d.valid = 1'b1;
                    st_d.word  = {st_q.hi, dat_i};
                end else begin
                    st_d.half = 1'b1;
                    st_d.hi   = dat_i;
                end
            end
            SK_SYNC: st_d.half = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;

    AST_PAIR_HAS_HIGH: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> $past(st_q.half)); // R2

    AST_SYNC_DROPS_HALF: assert property (@(posedge clk) disable iff (rst)
        (kind_i == SK_SYNC) |=> (!st_q.half && !st_q.valid)); // R7

endmodule

// File: rtl/cam_coord_tracker.sv
module cam_coord_tracker
    import cam_pix_pkg::*;
#(
    parameter int H_W = 11,
    parameter int V_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stb_i,
    input  logic           hs_n_i,
    input  logic           vs_n_i,
    input  logic           fire_i,
    output logic [H_W-1:0] h_o,
    output logic [V_W-1:0] v_o
);

    typedef struct packed {
        logic           hs_prev;
        logic [H_W-1:0] hcnt;
        logic [V_W-1:0] vcnt;
        logic [H_W-1:0] h_out;
        logic [V_W-1:0] v_out;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       row_end;

    // falling horizontal sync, judged only against the previous sample point
    assign row_end = st_q.hs_prev & ~hs_n_i;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            st_d.hs_prev = hs_n_i;
            if (!vs_n_i) begin
                st_d.hcnt = '0;
                st_d.vcnt = '0;
            end else if (row_end) begin
                st_d.hcnt = '0;
                st_d.vcnt = st_q.vcnt + 1'b1;
            end else if (fire_i) begin
                st_d.h_out = st_q.hcnt;
                st_d.v_out = st_q.vcnt;
                st_d.hcnt  = st_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_o = st_q.h_out;
    assign v_o = st_q.v_out;

    AST_FRAME_HOME: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !vs_n_i) |=> (st_q.hcnt == '0 && st_q.vcnt == '0)); // R6

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (stb_i && vs_n_i && st_q.hs_prev && !hs_n_i)
            |=> (st_q.hcnt == '0 && st_q.vcnt == $past(st_q.vcnt) + 1'b1)); // R5

    AST_COORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire_i |=> ($stable(st_q.h_out) && $stable(st_q.v_out))); // R4

endmodule

// File: rtl/cam_pix_rebuild.sv
module cam_pix_rebuild
    import cam_pix_pkg::*;
#(
    parameter int H_W = 11,
    parameter int V_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cam_pclk_i,
    input  logic                  cam_hsync_n_i,
    input  logic                  cam_vsync_n_i,
    input  logic [CAM_BYTE_W-1:0] cam_byte_i,
    output logic                  pix_valid_o,
    output logic [H_W-1:0]        pix_h_o,
    output logic [V_W-1:0]        pix_v_o,
    output logic [PIX_W-1:0]      pix_data_o
);

    logic      smp_stb;
    smp_kind_e smp_kind;
    logic      smp_hs_n;
    logic      smp_vs_n;
    cam_byte_t smp_dat;
    logic      pair_fire;

    cam_edge_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .pclk_i (cam_pclk_i),
        .hs_n_i (cam_hsync_n_i),
        .vs_n_i (cam_vsync_n_i),
        .dat_i  (cam_byte_i),
        .stb_o  (smp_stb),
        .kind_o (smp_kind),
        .hs_n_o (smp_hs_n),
        .vs_n_o (smp_vs_n),
        .dat_o  (smp_dat)
    );

    cam_byte_pairer u_pairer (
        .clk     (clk),
        .rst     (rst),
        .kind_i  (smp_kind),
        .dat_i   (smp_dat),
        .fire_o  (pair_fire),
        .valid_o (pix_valid_o),
        .word_o  (pix_data_o)
    );

    cam_coord_tracker #(
        .H_W (H_W),
        .V_W (V_W)
    ) u_tracker (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (smp_stb),
        .hs_n_i (smp_hs_n),
        .vs_n_i (smp_vs_n),
        .fire_i (pair_fire),
        .h_o    (pix_h_o),
        .v_o    (pix_v_o)
    );

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |=> !pix_valid_o); // R8

    AST_VALID_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> $past(smp_stb)); // R1

endmodule

// File: tb/cam_pix_rebuild_tb.sv
module cam_pix_rebuild_tb_top;

    localparam int CLK_NS  = 10;
    localparam int TB_H_W  = 4;
    localparam int TB_V_W  = 3;
    localparam int WD_CYC  = 100000;

    typedef struct packed {
        logic [TB_H_W-1:0] h;
        logic [TB_V_W-1:0] v;
        logic [15:0]       d;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pclk = 1'b0;
    logic              hs_n = 1'b1;
    logic              vs_n = 1'b1;
    logic [7:0]        cbyte = 8'h00;
    logic              valid;
    logic [TB_H_W-1:0] ph;
    logic [TB_V_W-1:0] pv;
    logic [15:0]       pdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [TB_H_W-1:0] exp_h = '0;
    logic [TB_V_W-1:0] exp_v = '0;

    always #(CLK_NS/2) clk = ~clk;

    cam_pix_rebuild #(.H_W(TB_H_W), .V_W(TB_V_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cam_pclk_i    (pclk),
        .cam_hsync_n_i (hs_n),
        .cam_vsync_n_i (vs_n),
        .cam_byte_i    (cbyte),
        .pix_valid_o   (valid),
        .pix_h_o       (ph),
        .pix_v_o       (pv),
        .pix_data_o    (pdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    // One pixel-clock period: low 2 cycles, high 2 cycles. Bus is corrupted while high (R1).
    task automatic tick(input logic hs, input logic vs, input logic [7:0] b);
        @(negedge clk);
        pclk  = 1'b0;
        hs_n  = hs;
        vs_n  = vs;
        cbyte = b;
        repeat (2) @(negedge clk);
        pclk = 1'b1;
        @(negedge clk);
        cbyte = ~b;
        hs_n  = ~hs;
        vs_n  = ~vs;
        @(negedge clk);
    endtask

    task automatic send_pixel(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        exp_t e;
        e.h = exp_h;
        e.v = exp_v;
        e.d = {hi, lo};
        exp_h = exp_h + 1'b1;
        tick(1'b1, 1'b1, hi);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick(1'b1, 1'b1, lo);
    endtask

    task automatic send_row(input int npix, input logic [7:0] seed, input string tag);
        for (int i = 0; i < npix; i++)
            send_pixel(seed + 8'(2*i), 8'h5A ^ (seed + 8'(i)), tag);
    endtask

    // Horizontal blanking with vertical sync high: data on the bus is ignored (R3, R5)
    task automatic row_gap(input int n);
        for (int i = 0; i < n; i++)
            tick(1'b0, 1'b1, 8'hC3 + 8'(i));
        exp_h = '0;
        exp_v = exp_v + 1'b1;
    endtask

    // Vertical blanking with horizontal sync toggling (R6)
    task automatic frame_gap(input int n);
        for (int i = 0; i < n; i++)
            tick((i % 2) == 0, 1'b0, 8'h3C + 8'(i));
        tick(1'b1, 1'b0, 8'hEE);
        exp_h = '0;
        exp_v = '0;
    endtask

    // Scoreboard monitor
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                check(!prev_valid, "R8 valid lasted more than one cycle", 32'(prev_valid), 32'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R7 unexpected pixel", 32'(pdata), 32'hFFFFFFFF);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(pdata == e.d, {t, " data"}, 32'(pdata), 32'(e.d));
                    check(ph == e.h, {t, " hcount"}, 32'(ph), 32'(e.h));
                    check(pv == e.v, {t, " vcount"}, 32'(pv), 32'(e.v));
                end
            end
            prev_valid = valid;
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog: got 0 expected 1 (run did not complete)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(valid == 1'b0, "R10 valid in reset", 32'(valid), 32'd0);
        check(pdata == 16'h0, "R10 data in reset", 32'(pdata), 32'd0);
        check(ph == '0, "R10 hcount in reset", 32'(ph), 32'd0);
        check(pv == '0, "R10 vcount in reset", 32'(pv), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R10 valid after release", 32'(valid), 32'd0);

        // R6: frame start with horizontal sync toggling in vertical blanking
        frame_gap(5);
        // R1 R2 R4: first row, then R5 row advance
        send_row(5, 8'h10, "R1 R2 R4 first row");
        row_gap(3);
        send_row(4, 8'h80, "R2 R4 R5 second row");
        row_gap(2);
        // R7: odd trailing byte must be dropped
        send_row(2, 8'h20, "R5 row before odd byte");
        tick(1'b1, 1'b1, 8'hAA);
        row_gap(2);
        send_row(3, 8'h40, "R3 R7 row after odd byte");
        row_gap(1);
        // R6: mid-frame vertical sync returns to origin
        send_row(1, 8'h66, "R5 row before frame end");
        frame_gap(6);
        send_row(2, 8'h90, "R6 new frame origin");
        row_gap(2);
        // R9: horizontal wrap at 4 bits
        send_row(18, 8'h01, "R4 R9 horizontal wrap");
        row_gap(2);
        // R9: vertical wrap at 3 bits
        for (int r = 0; r < 8; r++) begin
            send_row(1, 8'(8'hB0 + r), "R5 R9 vertical wrap");
            row_gap(2);
        end
        frame_gap(3);
        send_row(2, 8'hD0, "R6 second frame origin");
        row_gap(2);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 pixels missing at end", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule